// File: doc/BRIEF.md
# RMII Transmit Framer

The block turns a byte stream holding one Ethernet frame, from the destination address through the last payload byte, into the two-bit transmit data lines and the transmit enable of a reduced media independent interface. It sends one dibit per reference-clock cycle. The frame bytes arrive over a valid/ready handshake that marks the first byte with a start flag and the final byte with an end flag. The block stores the whole frame while it arrives and keeps a running CRC-32 over it. Only when the end flag shows that the length is legal does it start the line sequence: preamble, delimiter, payload, frame check sequence, then a fixed idle gap.

An illegal length, either too short or too long, is reported with a one-cycle error pulse and nothing is sent. Because the block stores the frame first, a rejected frame never reaches the wire. The limits are parameters (60 and 1518 bytes by default, CRC excluded). While a frame is on the wire or in its idle gap, the input side is held off, so the producer simply waits on ready.

Top module: `rmii_tx_framer`

## Requirements
- R1: Out of synchronous reset (rst_n low at a rising edge), the next cycle shows tx_en=0, txd=00, busy=0, len_err=0 and in_ready=1.
- R2: In the cycle after the end-flagged byte of a legal frame is accepted, tx_en rises and the line carries 31 preamble dibits with txd[0]=1, txd[1]=0.
- R3: The preamble is followed by exactly one delimiter dibit txd=11 with tx_en high.
- R4: Each stored byte is then sent as four dibits with tx_en high, in the order bits[1:0], [3:2], [5:4], [7:6], bytes in arrival order.
- R5: Directly after the last data dibit, with no idle cycle, the 32-bit check value is sent low byte first and low dibit first. The check value is the reflected CRC-32 (polynomial 0xEDB88320, preset to all ones, result inverted); the bytes 0x31..0x39 ("123456789") give 0xCBF43926.
- R6: After the check value the line is idle for 48 cycles with tx_en=0 and txd=00. in_ready stays low from the acceptance of the end-flagged byte until the last idle cycle, and is high in the cycle after it.
- R7: A frame of fewer than MIN_LEN or more than MAX_LEN bytes gives len_err=1 for exactly the one cycle after its end-flagged byte. tx_en stays low for it, and in_ready is high again in that same cycle.
- R8: A byte accepted while no frame is open and without the start flag is discarded, even if it carries the end flag: it causes no transmission and no len_err.
- R9: A start-flagged byte that arrives while a frame is open discards the bytes gathered so far and begins a new frame with itself as byte 0.
- R10: busy is high from the cycle after the first byte of a frame is accepted until the last idle-gap cycle, and is low when idle.
- R11: Cycles with in_valid low between the bytes of a frame do not change what is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | in_data holds a byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block takes the byte at this edge when in_valid is high |
| txd | output | 2 | Transmit dibit, txd[0] first bit of the pair |
| tx_en | output | 1 | Transmit enable |
| busy | output | 1 | A frame is being gathered, sent or followed by its gap |
| len_err | output | 1 | One-cycle pulse for a frame of illegal length |

## Verification
A wrong phase counter shows as a preamble or gap of the wrong length, or as a delimiter in the wrong cycle. This is visible on txd and tx_en within one frame of the fault. A bad store pointer or CRC update shows as wrong dibits in the data or check-value phase of the very frame it touches. The bench compares every dibit of every frame against values it computes itself. A wrong length decision shows either as a missing len_err pulse or as a transmission that should not happen, in the cycle after the end byte. The bench sweeps every length from below the minimum to above the maximum of a small configuration.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_SFD,
      PH_DATA,
      PH_FCS,
      PH_GAP
   } phase_e;

   // one byte through the reflected CRC-32, least significant bit first
   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int k = 0; k < 8; k++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/rmii_tx_store.sv
module rmii_tx_store #(
   parameter int DEPTH = 1518,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);

   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/rmii_tx_crc.sv
module rmii_tx_crc
   import rmii_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        step,
   input  logic [7:0]  data,
   output logic [31:0] fcs
);

   logic [31:0] crc_q;
   logic [31:0] base;

   assign base = restart ? 32'hFFFF_FFFF : crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= 32'hFFFF_FFFF;
      end else if (step) begin
         crc_q <= crc32_step(base, data);
      end
   end

   assign fcs = ~crc_q;

endmodule

// File: rtl/rmii_tx_intake.sv
module rmii_tx_intake #(
   parameter int MIN_LEN = 60,
   parameter int MAX_LEN = 1518,
   localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
   localparam int LW = $clog2(MAX_LEN + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          sof,
   input  logic          eof,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          crc_restart,
   output logic          crc_step,
   output logic          launch,
   output logic [LW-1:0] launch_len,
   output logic          gathering,
   output logic          len_err
);

   localparam logic [LW-1:0] MIN_L = LW'(MIN_LEN);
   localparam logic [LW-1:0] MAX_L = LW'(MAX_LEN);
   localparam logic [LW-1:0] SAT_L = LW'(MAX_LEN + 1);

   logic          open_q;
   logic [LW-1:0] cnt_q;
   logic [LW-1:0] cnt_nx;
   logic          take;
   logic          finish;
   logic          legal;
   logic          err_q;

   assign take   = accept & (sof | open_q);
   assign cnt_nx = sof ? LW'(1) : ((cnt_q == SAT_L) ? cnt_q : cnt_q + LW'(1));
   assign finish = take & eof;
   assign legal  = (cnt_nx >= MIN_L) && (cnt_nx <= MAX_L);

   assign wr_en       = take & (sof | (cnt_q < MAX_L));
   assign wr_addr     = sof ? '0 : cnt_q[AW-1:0];
   assign crc_restart = accept & sof;
   assign crc_step    = take;
   assign launch      = finish & legal;
   assign launch_len  = cnt_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= finish & ~legal;
         if (take) begin
            cnt_q  <= cnt_nx;
            open_q <= ~eof;
         end
      end
   end

   assign gathering = open_q;
   assign len_err   = err_q;

endmodule

// File: rtl/rmii_tx_serial.sv
module rmii_tx_serial
   import rmii_tx_pkg::*;
#(
   parameter int MAX_LEN    = 1518,
   parameter int PRE_DIBITS = 31,
   parameter int GAP_DIBITS = 48,
   localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
   localparam int LW = $clog2(MAX_LEN + 2),
   localparam int CMAX = (PRE_DIBITS > GAP_DIBITS) ? PRE_DIBITS : GAP_DIBITS,
   localparam int CW = $clog2(((CMAX > 16) ? CMAX : 16) + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [LW-1:0] launch_len,
   input  logic [7:0]    rd_data,
   input  logic [31:0]   fcs,
   output logic [AW-1:0] rd_addr,
   output logic [1:0]    txd,
   output logic          tx_en,
   output logic          active
);

   localparam logic [CW-1:0] PRE_LAST = CW'(PRE_DIBITS - 1);
   localparam logic [CW-1:0] GAP_LAST = CW'(GAP_DIBITS - 1);
   localparam logic [CW-1:0] FCS_LAST = CW'(15);

   phase_e        ph_q;
   logic [CW-1:0] cnt_q;
   logic [LW-1:0] len_q;
   logic [LW-1:0] idx_q;
   logic [1:0]    sub_q;
   logic [31:0]   sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         len_q <= '0;
         idx_q <= '0;
         sub_q <= '0;
         sh_q  <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (launch) begin
                  ph_q  <= PH_PRE;
                  cnt_q <= '0;
                  len_q <= launch_len;
                  idx_q <= '0;
               end
            end
            PH_PRE: begin
               if (cnt_q == PRE_LAST) begin
                  ph_q <= PH_SFD;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            PH_SFD: begin
               ph_q  <= PH_DATA;
               sh_q  <= {24'h0, rd_data};
               idx_q <= idx_q + LW'(1);
               sub_q <= '0;
            end
            PH_DATA: begin
               sub_q <= sub_q + 2'd1;
               if (sub_q == 2'd3) begin
                  if (idx_q == len_q) begin
                     ph_q  <= PH_FCS;
                     sh_q  <= fcs;
                     cnt_q <= '0;
                  end else begin
                     sh_q  <= {24'h0, rd_data};
                     idx_q <= idx_q + LW'(1);
                  end
               end else begin
                  sh_q <= sh_q >> 2;
               end
            end
            PH_FCS: begin
               sh_q <= sh_q >> 2;
               if (cnt_q == FCS_LAST) begin
                  ph_q  <= PH_GAP;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            PH_GAP: begin
               if (cnt_q == GAP_LAST) begin
                  ph_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (ph_q)
         PH_PRE:          txd = 2'b01;
         PH_SFD:          txd = 2'b11;
         PH_DATA, PH_FCS: txd = sh_q[1:0];
         default:         txd = 2'b00;
      endcase
   end

   assign tx_en   = (ph_q == PH_PRE) | (ph_q == PH_SFD) | (ph_q == PH_DATA) | (ph_q == PH_FCS);
   assign active  = (ph_q != PH_IDLE);
   assign rd_addr = idx_q[AW-1:0];

endmodule

// File: rtl/rmii_tx_framer.sv
module rmii_tx_framer #(
   parameter int MIN_LEN    = 60,
   parameter int MAX_LEN    = 1518,
   parameter int PRE_DIBITS = 31,
   parameter int GAP_DIBITS = 48
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   input  logic       in_sof,
   input  logic       in_eof,
   output logic       in_ready,
   output logic [1:0] txd,
   output logic       tx_en,
   output logic       busy,
   output logic       len_err
);

   localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
   localparam int LW = $clog2(MAX_LEN + 2);

   generate
      if (MIN_LEN < 1 || MAX_LEN < MIN_LEN) begin : g_bad_len
         $error("rmii_tx_framer: need 1 <= MIN_LEN <= MAX_LEN");
      end
      if (PRE_DIBITS < 1 || GAP_DIBITS < 1) begin : g_bad_phase
         $error("rmii_tx_framer: preamble and gap need at least one dibit");
      end
   endgenerate

   logic          accept;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;
   logic          crc_restart;
   logic          crc_step;
   logic [31:0]   fcs;
   logic          launch;
   logic [LW-1:0] launch_len;
   logic          gathering;
   logic          active;

   assign in_ready = ~active;
   assign accept   = in_valid & in_ready;
   assign busy     = gathering | active;

   rmii_tx_intake #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_intake (
      .clk(clk), .rst_n(rst_n), .accept(accept), .sof(in_sof), .eof(in_eof),
      .wr_en(wr_en), .wr_addr(wr_addr), .crc_restart(crc_restart), .crc_step(crc_step),
      .launch(launch), .launch_len(launch_len), .gathering(gathering), .len_err(len_err)
   );

   rmii_tx_store #(.DEPTH(MAX_LEN)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   rmii_tx_crc u_crc (
      .clk(clk), .rst_n(rst_n), .restart(crc_restart), .step(crc_step),
      .data(in_data), .fcs(fcs)
   );

   rmii_tx_serial #(.MAX_LEN(MAX_LEN), .PRE_DIBITS(PRE_DIBITS), .GAP_DIBITS(GAP_DIBITS)) u_serial (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_len(launch_len),
      .rd_data(rd_data), .fcs(fcs), .rd_addr(rd_addr), .txd(txd), .tx_en(tx_en),
      .active(active)
   );

endmodule

// File: rtl/rmii_tx_framer_chk.sv
module rmii_tx_framer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_ready,
   input logic [1:0] txd,
   input logic       tx_en,
   input logic       busy,
   input logic       len_err
);

   // R1: reset clears the line and flags
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!tx_en && !busy && !len_err && in_ready));

   // R2: every burst opens with a preamble dibit
   a_r2_burst_starts_preamble: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> (txd == 2'b01));

   // R6: input held off while on the wire
   a_r6_no_ready_on_wire: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> !in_ready);

   // R6: gap starts with input still held off
   a_r6_gap_holds_input: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |-> (!in_ready && txd == 2'b00));

   // R7: rejected frame sends nothing and the flag is a single pulse
   a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> (!tx_en && in_ready));

   a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |=> !len_err);

   // R10: any held-off or driving cycle counts as busy
   a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en || !in_ready) |-> busy);

endmodule

bind rmii_tx_framer rmii_tx_framer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .txd(txd), .tx_en(tx_en),
   .busy(busy), .len_err(len_err)
);

// File: tb/sim_rmii_tx_framer.sv
module sim_rmii_tx_framer;

   localparam int MINL = 6;
   localparam int MAXL = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_sof = 1'b0;
   logic       in_eof = 1'b0;
   logic       in_ready;
   logic [1:0] txd;
   logic       tx_en;
   logic       busy;
   logic       len_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] fb [64];

   always #5 clk = ~clk;

   rmii_tx_framer #(.MIN_LEN(MINL), .MAX_LEN(MAXL)) u0 (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .txd(txd),
      .tx_en(tx_en), .busy(busy), .len_err(len_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input int n);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic fbit = c[0] ^ fb[i][b];
            c = c >> 1;
            if (fbit) c = c ^ 32'hEDB88320;
         end
      end
      return ~c;
   endfunction

   task automatic send_byte(input logic [7:0] d, input logic s, input logic e, input int idle);
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < idle; k++) @(negedge clk);
      in_data = d; in_sof = s; in_eof = e; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic send_frame(input int n, input int idle);
      for (int i = 0; i < n; i++) send_byte(fb[i], i == 0, i == n - 1, idle);
   endtask

   // sampling begins at the first negedge after the end byte was taken
   task automatic expect_tx(input int n, input string tag);
      int bad_pre = 0, bad_sfd = 0, bad_dat = 0, bad_fcs = 0, bad_gap = 0, bad_rdy = 0;
      logic [31:0] crc = ref_crc(n);
      for (int i = 0; i < 31; i++) begin
         @(negedge clk); in_valid = 1'b0;
         if (!(tx_en === 1'b1 && txd === 2'b01 && busy === 1'b1)) bad_pre++;
         if (in_ready !== 1'b0) bad_rdy++;
      end
      check({"R2 preamble ", tag}, bad_pre, 0);
      @(negedge clk);
      if (!(tx_en === 1'b1 && txd === 2'b11)) bad_sfd++;
      check({"R3 delimiter ", tag}, bad_sfd, 0);
      for (int i = 0; i < n; i++) begin
         for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            if (!(tx_en === 1'b1 && txd === fb[i][2*q +: 2])) bad_dat++;
            if (in_ready !== 1'b0) bad_rdy++;
         end
      end
      check({"R4 data ", tag}, bad_dat, 0);
      for (int q = 0; q < 16; q++) begin
         @(negedge clk);
         if (!(tx_en === 1'b1 && txd === crc[2*q +: 2])) bad_fcs++;
      end
      check({"R5 fcs ", tag}, bad_fcs, 0);
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         if (!(tx_en === 1'b0 && txd === 2'b00 && busy === 1'b1)) bad_gap++;
         if (in_ready !== 1'b0) bad_rdy++;
      end
      check({"R6 gap ", tag}, bad_gap, 0);
      check({"R6 ready low ", tag}, bad_rdy, 0);
      @(negedge clk);
      check({"R6 ready back ", tag}, in_ready, 1);
      check({"R10 busy off ", tag}, busy, 0);
   endtask

   task automatic expect_reject(input string tag);
      int bad = 0;
      @(negedge clk); in_valid = 1'b0;
      check({"R7 err pulse ", tag}, {len_err, tx_en, in_ready}, 3'b101);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (len_err !== 1'b0 || tx_en !== 1'b0) bad++;
      end
      check({"R7 silent ", tag}, bad, 0);
   endtask

   task automatic fill(input int n, input int seed);
      for (int i = 0; i < n; i++) fb[i] = 8'((i * 37 + seed * 11 + 5) & 255);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1
      check("R1 reset outputs", {tx_en, txd, busy, len_err, in_ready}, 6'b000001);

      // length sweep R2..R7
      for (int n = MINL - 2; n <= MAXL + 2; n++) begin
         fill(n, n);
         send_frame(n, 0);
         if (n < MINL || n > MAXL) expect_reject($sformatf("len %0d", n));
         else expect_tx(n, $sformatf("len %0d", n));
      end

      // far overlength R7
      fill(30, 3);
      send_frame(30, 0);
      expect_reject("len 30");

      // known CRC value R5
      for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
      check("R5 crc of 123456789", ref_crc(9), 32'hCBF43926);
      send_frame(9, 0);
      expect_tx(9, "ascii");

      // stray bytes without start flag R8
      send_byte(8'hAA, 1'b0, 1'b0, 0);
      send_byte(8'h55, 1'b0, 1'b1, 0);
      @(negedge clk); in_valid = 1'b0;
      check("R8 stray bytes ignored", {len_err, tx_en, busy}, 3'b000);
      fill(8, 21);
      send_frame(8, 0);
      expect_tx(8, "after stray");

      // restart on new start flag R9
      fill(5, 40);
      for (int i = 0; i < 5; i++) send_byte(fb[i], i == 0, 1'b0, 0);
      @(negedge clk); in_valid = 1'b0;
      check("R10 busy while gathering", busy, 1);
      fill(7, 9);
      send_frame(7, 0);
      expect_tx(7, "R9 restart");

      // idle cycles between bytes R11
      fill(10, 77);
      send_frame(10, 3);
      expect_tx(10, "R11 valid gaps");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule